// File: doc/BRIEF.md
# Banked Memory Mapper with Clock-Register Window

This block sits between an 8-bit CPU with a 16-bit address bus and the cartridge memories. It turns CPU addresses into physical ROM and RAM addresses. The lower half of the address space holds two 16 KiB ROM windows. The first window is always bank 0. The second window shows a bank picked by a 7-bit register. The region 0xA000–0xBFFF is an 8 KiB external window. It reaches one of four RAM banks, or one of five clock-register slots that are stubbed out and read as zero.

The CPU programs the mapper by writing into the ROM address space. Bits 14:13 of the address choose the target:

- 0b00 is the window enable, which is unlocked by a key value.
- 0b01 is the ROM bank.
- 0b10 is the external select.
- 0b11 is the clock latch command, which is accepted and discarded.

A control write takes effect on the clock edge that samples it. All translation is combinational from the registered state. The clock counters and the memory arrays are not part of this block.

Top module: `bank_mapper`

## Requirements
- R1: After a synchronous active-low reset, the ROM bank is 1, the external select is 0 and the external window is disabled.
- R2: A write of 0x0A to 0x0000–0x1FFF enables the external window. A write of 0x00 there disables it. Any other value leaves the enable unchanged.
- R3: A write to 0x2000–0x3FFF loads the ROM bank from data bit 6 to bit 0. Bit 7 is discarded, and bank 0 is kept as 0 with no remapping.
- R4: A read of 0x0000–0x3FFF asserts rom_cs with rom_addr equal to the CPU address, so the bank is always 0.
- R5: A read of 0x4000–0x7FFF asserts rom_cs with rom_addr = bank × 0x4000 + (address − 0x4000).
- R6: A write of 0x00–0x03 to 0x4000–0x5FFF selects that RAM bank. While the window is enabled, an access to 0xA000–0xBFFF asserts ram_cs with ram_addr = bank × 0x2000 + (address − 0xA000). ram_we follows a write strobe.
- R7: A write of 0x08–0x0C to 0x4000–0x5FFF selects a clock slot. While the window is enabled and a slot is selected, window reads drive ext_oe with ext_rdata 0x00, and window writes raise neither ram_cs nor ram_we.
- R8: Any other value written to 0x4000–0x5FFF keeps the previous selection.
- R9: Writes to 0x6000–0x7FFF change neither the ROM bank, the select nor the enable.
- R10: While the window is disabled, window reads drive ext_oe with ext_rdata 0xFF, and no window access raises ram_cs or ram_we.
- R11: Accesses to 0x8000–0x9FFF and 0xC000–0xFFFF raise none of rom_cs, ram_cs, ram_we or ext_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_cs | output | 1 | ROM select for a read of the ROM windows |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ext_rdata | output | 8 | Data the mapper drives itself (clock slot or disabled window) |
| ext_oe | output | 1 | ext_rdata is valid and should be driven onto the bus |

## Verification
The bench tries several input patterns:

- It loads all 256 data values into the ROM bank, so a dropped bit 7, a zero remap or a bank offset error each yields a distinct rom_addr.
- It writes all 256 values to the enable register from both a set state and a clear state. This separates "only the key unlocks" from "any non-zero unlocks" and from "other values clear".
- It writes all 256 values to the select register on top of a RAM-bank selection and on top of a clock-slot selection. This separates the RAM range, the slot range and the ignored values, and shows the kept selection by its previous kind.
- It sweeps the latch range, the fixed ROM window and the unmapped regions with offsets scattered across each window.

// File: rtl/bank_mapper_pkg.sv
// Package: shared constants and types of the banked mapper.
// Assumes a 16-bit CPU address bus with the control space in 0x0000-0x7FFF.
package bank_mapper_pkg;

    // Control target chosen by address bits 14:13 during a write below 0x8000
    typedef enum logic [1:0] {
        CTL_ENABLE  = 2'd0,
        CTL_ROMBANK = 2'd1,
        CTL_EXTSEL  = 2'd2,
        CTL_LATCH   = 2'd3
    } ctl_field_e;

    localparam logic [7:0] WIN_UNLOCK_KEY = 8'h0A;
    localparam logic [7:0] WIN_LOCK_KEY   = 8'h00;
    localparam logic [7:0] SLOT_FIRST     = 8'h08;
    localparam logic [7:0] SLOT_LAST      = 8'h0C;
    localparam logic [7:0] OPEN_BUS_DATA  = 8'hFF;
    localparam logic [7:0] SLOT_READ_DATA = 8'h00;

    localparam int unsigned CPU_AW     = 16;
    localparam int unsigned ROM_WIN_AW = 14;
    localparam int unsigned EXT_WIN_AW = 13;

endpackage

// File: rtl/mapper_ctrl_regs.sv
// Module: mapper_ctrl_regs
// Holds the ROM bank, the external select and the window enable.
// Assumes that wr_en is already qualified to the control address space and
// that field names the target register. A write lands on the sampling edge.
module mapper_ctrl_regs
    import bank_mapper_pkg::*;
#(
    parameter int unsigned ROM_BANK_W = 7,
    parameter int unsigned RAM_BANK_W = 2,
    parameter int unsigned SEL_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  ctl_field_e            field,
    input  logic [7:0]            wdata,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [SEL_W-1:0]      ext_sel,
    output logic                  ext_en
);
    localparam int unsigned RAM_BANKS = 1 << RAM_BANK_W;

    logic sel_valid;

    // Decide whether a select value names a RAM bank or a clock slot
    always_comb begin
        sel_valid = (wdata < 8'(RAM_BANKS)) ||
                    ((wdata >= SLOT_FIRST) && (wdata <= SLOT_LAST));
    end

    // Window enable: only the two key values change it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_en <= 1'b0;
        end else if (wr_en && field == CTL_ENABLE) begin
            if (wdata == WIN_UNLOCK_KEY) begin
                ext_en <= 1'b1;
            end else if (wdata == WIN_LOCK_KEY) begin
                ext_en <= 1'b0;
            end
        end
    end

    // Switchable ROM bank: direct load, no remap of bank 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_bank <= ROM_BANK_W'(1);
        end else if (wr_en && field == CTL_ROMBANK) begin
            rom_bank <= wdata[ROM_BANK_W-1:0];
        end
    end

    // External select: loads only legal RAM bank or clock slot values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sel <= '0;
        end else if (wr_en && field == CTL_EXTSEL && sel_valid) begin
            ext_sel <= wdata[SEL_W-1:0];
        end
    end

endmodule

// File: rtl/mapper_rom_xlate.sv
// Module: mapper_rom_xlate
// Maps CPU reads of 0x0000-0x7FFF to a physical ROM address. The lower
// window is pinned to bank 0 and the upper window uses the bank register.
// Assumes that the bank register is stable during the access.
module mapper_rom_xlate
    import bank_mapper_pkg::*;
#(
    parameter int unsigned ROM_BANK_W = 7,
    localparam int unsigned ROM_AW    = ROM_BANK_W + ROM_WIN_AW
) (
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic                  cpu_rd,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic                  rom_cs
);
    logic [ROM_BANK_W-1:0] eff_bank;

    // Pick bank 0 for the fixed window and the register for the switchable one
    always_comb begin
        eff_bank = cpu_addr[ROM_WIN_AW] ? rom_bank : '0;
        rom_addr = {eff_bank, cpu_addr[ROM_WIN_AW-1:0]};
        rom_cs   = cpu_rd && !cpu_addr[CPU_AW-1];
    end

endmodule

// File: rtl/mapper_ext_xlate.sv
// Module: mapper_ext_xlate
// Decodes the 8 KiB external window at 0xA000-0xBFFF. It sends an access
// to a RAM bank, answers a selected clock slot with zero, or answers with
// open-bus data while the window is locked.
// Assumes that select values are always legal, as the register file keeps them.
module mapper_ext_xlate
    import bank_mapper_pkg::*;
#(
    parameter int unsigned RAM_BANK_W = 2,
    parameter int unsigned SEL_W      = 4,
    localparam int unsigned RAM_AW    = RAM_BANK_W + EXT_WIN_AW,
    localparam int unsigned RAM_BANKS = 1 << RAM_BANK_W
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [SEL_W-1:0]  ext_sel,
    input  logic              ext_en,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [7:0]        ext_rdata,
    output logic              ext_oe
);
    logic in_win;
    logic sel_is_ram;

    // Window hit and kind of selection
    always_comb begin
        in_win     = (cpu_addr[CPU_AW-1:EXT_WIN_AW] == 3'b101);
        sel_is_ram = (ext_sel < SEL_W'(RAM_BANKS));
    end

    // RAM path: address build and strobes, only when unlocked on a RAM bank
    always_comb begin
        ram_addr = {ext_sel[RAM_BANK_W-1:0], cpu_addr[EXT_WIN_AW-1:0]};
        ram_cs   = in_win && ext_en && sel_is_ram && (cpu_rd || cpu_wr);
        ram_we   = ram_cs && cpu_wr;
    end

    // Self-driven read data: open bus when locked, zero for a clock slot
    always_comb begin
        ext_oe    = in_win && cpu_rd && (!ext_en || !sel_is_ram);
        ext_rdata = ext_en ? SLOT_READ_DATA : OPEN_BUS_DATA;
    end

endmodule

// File: rtl/bank_mapper.sv
// Module: bank_mapper (top)
// Banked memory mapper for a 16-bit CPU bus. Writes below 0x8000 program
// the control registers. Reads there go to ROM, and 0xA000-0xBFFF goes to
// RAM or the clock slots.
// Assumes one access per cycle with rd and wr not both set.
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int unsigned ROM_BANK_W = 7,
    parameter int unsigned RAM_BANK_W = 2,
    parameter int unsigned SEL_W      = 4,
    localparam int unsigned ROM_AW    = ROM_BANK_W + ROM_WIN_AW,
    localparam int unsigned RAM_AW    = RAM_BANK_W + EXT_WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_cs,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [7:0]        ext_rdata,
    output logic              ext_oe
);
    logic                  ctl_we;
    ctl_field_e            ctl_field;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [SEL_W-1:0]      ext_sel;
    logic                  ext_en;

    // Control decode: any write below 0x8000, target from bits 14:13
    always_comb begin
        ctl_we    = cpu_wr && !cpu_addr[CPU_AW-1];
        ctl_field = ctl_field_e'(cpu_addr[14:13]);
    end

    mapper_ctrl_regs #(
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W),
        .SEL_W      (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_we),
        .field    (ctl_field),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank),
        .ext_sel  (ext_sel),
        .ext_en   (ext_en)
    );

    mapper_rom_xlate #(
        .ROM_BANK_W (ROM_BANK_W)
    ) u_rom (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .rom_bank (rom_bank),
        .rom_addr (rom_addr),
        .rom_cs   (rom_cs)
    );

    mapper_ext_xlate #(
        .RAM_BANK_W (RAM_BANK_W),
        .SEL_W      (SEL_W)
    ) u_ext (
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .ext_sel   (ext_sel),
        .ext_en    (ext_en),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .ext_rdata (ext_rdata),
        .ext_oe    (ext_oe)
    );

endmodule

// File: rtl/bank_mapper_chk.sv
// Module: bank_mapper_chk
// Temporal checks on the mapper's ports and its register state. It is
// attached to every bank_mapper instance by the bind statement below.
module bank_mapper_chk #(
    parameter int unsigned ROM_BANK_W = 7,
    parameter int unsigned SEL_W      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:0]           cpu_addr,
    input logic [7:0]            cpu_wdata,
    input logic                  cpu_wr,
    input logic                  rom_cs,
    input logic                  ram_cs,
    input logic                  ram_we,
    input logic                  ext_oe,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [SEL_W-1:0]      ext_sel,
    input logic                  ext_en
);
    logic       c_wr;
    logic [1:0] c_fld;
    assign c_wr  = cpu_wr && (cpu_addr[15] == 1'b0);
    assign c_fld = cpu_addr[14:13];

    // R1: register values in the first cycle after reset
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rom_bank == ROM_BANK_W'(1) && ext_sel == '0 && !ext_en));

    // R2: the unlock key sets the enable
    a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_fld == 2'd0 && cpu_wdata == 8'h0A) |=> ext_en);

    // R2: non-key values leave the enable alone
    a_r2_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_fld == 2'd0 && cpu_wdata != 8'h0A && cpu_wdata != 8'h00)
        |=> $stable(ext_en));

    // R3: the bank takes the low data bits
    a_r3_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_fld == 2'd1) |=> (rom_bank == $past(cpu_wdata[ROM_BANK_W-1:0])));

    // R8: illegal select values are dropped
    a_r8_sel_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_fld == 2'd2 && cpu_wdata > 8'h03 &&
         (cpu_wdata < 8'h08 || cpu_wdata > 8'h0C)) |=> $stable(ext_sel));

    // R9: latch writes change no state
    a_r9_latch_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_fld == 2'd3) |=> ($stable(rom_bank) && $stable(ext_sel) && $stable(ext_en)));

    // R10: a locked window never reaches RAM
    a_r10_locked_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> (!ram_cs && !ram_we));

    // R7: a clock slot never reaches RAM
    a_r7_slot_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel >= SEL_W'(8)) |-> (!ram_cs && !ram_we));

    // R11: at most one target responds to an access
    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, ram_cs, ext_oe}));

endmodule

bind bank_mapper bank_mapper_chk #(
    .ROM_BANK_W (ROM_BANK_W),
    .SEL_W      (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ext_oe    (ext_oe),
    .rom_bank  (rom_bank),
    .ext_sel   (ext_sel),
    .ext_en    (ext_en)
);

// File: tb/bank_mapper_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every control value and scattered addresses. A reference
// state built from the requirements predicts every output.
module bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [20:0] rom_addr;
    logic        rom_cs;
    logic [14:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;
    logic [7:0]  ext_rdata;
    logic        ext_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    int m_bank = 1;
    int m_sel = 0;
    bit m_en = 0;

    always #2.5 clk = ~clk;

    bank_mapper u_dut (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
        .cpu_wr (cpu_wr), .cpu_rd (cpu_rd), .rom_addr (rom_addr), .rom_cs (rom_cs),
        .ram_addr (ram_addr), .ram_cs (ram_cs), .ram_we (ram_we),
        .ext_rdata (ext_rdata), .ext_oe (ext_oe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Control write; the reference state follows the requirements
    task automatic ctl_write(input int a, input int d);
        @(negedge clk);
        cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(posedge clk);
        #1 cpu_wr = 1'b0;
        if (a < 'h8000) begin
            case ((a >> 13) & 3)
                0: if (d == 'h0A) m_en = 1; else if (d == 'h00) m_en = 0; // R2
                1: m_bank = d & 'h7F;                                      // R3
                2: if (d <= 3 || (d >= 8 && d <= 12)) m_sel = d;           // R6 R7 R8
                default: ;                                                 // R9
            endcase
        end
    endtask

    // One-cycle access that is withdrawn before the next edge; compares all outputs
    task automatic probe(input int a, input bit rd, input bit wr, input string tag = "");
        bit in_rom, in_ext, e_rom_cs, e_ram_cs, e_ram_we, e_oe;
        logic [20:0] e_rom_addr;
        logic [14:0] e_ram_addr;
        logic [7:0]  e_rdata;
        logic [63:0] act, exp;
        string req;
        in_rom = (a < 'h8000);
        in_ext = (a >= 'hA000 && a <= 'hBFFF);
        e_rom_cs = rd && in_rom;
        e_rom_addr = (a >= 'h4000) ? 21'(m_bank * 'h4000 + (a - 'h4000)) : 21'(a);
        e_ram_cs = (rd || wr) && in_ext && m_en && (m_sel < 4);
        e_ram_we = e_ram_cs && wr;
        e_ram_addr = 15'(m_sel * 'h2000 + (a - 'hA000));
        e_oe = rd && in_ext && (!m_en || m_sel >= 8);
        e_rdata = m_en ? 8'h00 : 8'hFF;
        if (tag != "") req = tag;
        else if (in_rom) req = (a < 'h4000) ? "R4" : "R5";
        else if (!in_ext) req = "R11";
        else if (!m_en) req = "R10";
        else if (m_sel < 4) req = "R6";
        else req = "R7";
        @(negedge clk);
        cpu_addr = 16'(a); cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h5A;
        #1;
        act = {rom_cs, (rom_cs ? rom_addr : 21'h0), ram_cs, ram_we,
               (ram_cs ? ram_addr : 15'h0), ext_oe, (ext_oe ? ext_rdata : 8'h0)};
        exp = {e_rom_cs, (e_rom_cs ? e_rom_addr : 21'h0), e_ram_cs, e_ram_we,
               (e_ram_cs ? e_ram_addr : 15'h0), e_oe, (e_oe ? e_rdata : 8'h0)};
        check(act == exp, req, act, exp);
        #1 cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, with bank 1 upstairs, the window locked and select 0
        probe('h4000, 1, 0, "R1");
        probe('h7FFF, 1, 0, "R1");
        probe('hA000, 1, 0, "R1");
        probe('hA000, 0, 1, "R1");
        ctl_write('h0000, 'h0A);
        probe('hA155, 1, 0, "R1");

        // R3 R5: every bank value, including bit 7 set and bank 0
        for (int v = 0; v < 256; v++) begin
            ctl_write('h2000 + ((v * 37) & 'h1FFF), v);
            probe('h4000, 1, 0, "R3");
            probe('h7FFF, 1, 0);
            probe('h4000 + ((v * 91) & 'h3FFF), 1, 0);
        end

        // R4: fixed window stays at bank 0 regardless of the register
        ctl_write('h3FFF, 'h55);
        for (int a = 0; a < 'h4000; a += 'h7F) probe(a, 1, 0);

        // R2: every enable value from both starting states
        ctl_write('h4000, 0);
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
                ctl_write('h1FFF, (s != 0) ? 'h0A : 'h00);
                ctl_write((v * 13) & 'h1FFF, v);
                probe('hA000 + v, 1, 0, "R2");
                probe('hA000 + v * 3, 0, 1, "R2");
            end
        end

        // R6 R7 R8: every select value on top of a RAM bank or a clock slot
        ctl_write('h0000, 'h0A);
        for (int v = 0; v < 256; v++) begin
            ctl_write('h4000, (v % 2 != 0) ? 2 : 9);
            ctl_write('h4000 | ((v * 7) & 'h1FFF), v);
            probe('hA000 + ((v * 29) & 'h1FFF), 1, 0,
                  (v <= 3) ? "R6" : ((v >= 8 && v <= 12) ? "R7" : "R8"));
            probe('hA000 + ((v * 41) & 'h1FFF), 0, 1,
                  (v <= 3) ? "R6" : ((v >= 8 && v <= 12) ? "R7" : "R8"));
        end

        // R9: latch-range writes leave bank, select and enable intact
        ctl_write('h2000, 'h33);
        ctl_write('h4000, 3);
        for (int v = 0; v < 256; v++) begin
            ctl_write('h6000 + ((v * 53) & 'h1FFF), v);
            probe('h4123, 1, 0, "R9");
            probe('hBFFF, 1, 0, "R9");
        end
        ctl_write('h0000, 'h00);
        ctl_write('h7000, 'h0A);
        probe('hA010, 1, 0, "R9");

        // R10: locked window on RAM and slot selections
        ctl_write('h4000, 1);
        probe('hA777, 1, 0);
        probe('hA777, 0, 1);
        ctl_write('h4000, 'h0C);
        probe('hBEEF, 1, 0);
        probe('hBEEF, 0, 1);

        // R11: unmapped regions, read and write, unlocked on a RAM bank
        ctl_write('h0000, 'h0A);
        ctl_write('h4000, 0);
        for (int a = 'h8000; a < 'hA000; a += 'hFF) begin
            probe(a, 1, 0); probe(a, 0, 1);
        end
        for (int a = 'hC000; a <= 'hFFFF; a += 'hFF) begin
            probe(a, 1, 0); probe(a, 0, 1);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule